// File: doc/BRIEF.md
# Hit-Frame Memory with Token-Passed Serial Readout

This block collects hit frames from a 64-channel front end during a bunch train and drains them between trains. Each channel presents two discriminator outputs, a low-threshold one and a high-threshold one. Together they form a 2-bit code per channel. A frame is stored on every crossing tick in which any channel shows a hit, while acquisition is enabled. A stored frame is 160 bits wide. It holds an 8-bit header, which is the configured chip identifier, the 24-bit crossing number of that crossing, and the codes of all 64 channels, including the channels that stayed quiet.

The memory keeps up to 128 frames. When every location is used, a full flag rises and later triggers are dropped, so no stored frame is ever overwritten. In the gap between trains, several chips share one serial data line and pass a token from one to the next. A chip drives the line only while it holds the token. It shifts out its frames oldest first, one bit per bit-rate enable, and the most significant bit goes first. After its last bit it hands the token on and empties its memory. A chip that holds no frames hands the token on at once.

Top module: `hit_frame_store`

## Requirements
- R1: In a stored frame, channel k occupies bits [2k+1:2k]. Bit 2k+1 is the high-threshold discriminator `disc_hi[k]` and bit 2k is the low-threshold discriminator `disc_lo[k]`. All 64 channels are recorded, whether or not they fired.
- R2: A frame is 160 bits wide. Bits [159:152] hold `chip_id` as sampled at the write, bits [151:128] hold the crossing number, and bits [127:0] hold the channel codes. The frame is sent on `sdo` from bit 159 down to bit 0.
- R3: A frame is written only in a cycle where `xing_tick`, `acq_on` and at least one set bit in `disc_lo` or `disc_hi` all hold. A crossing with no hit, a hit without a tick, or any hit while `acq_on` is low stores nothing.
- R4: The crossing number becomes 0 in the cycle after `train_start`, even when `xing_tick` is high in the same cycle. Otherwise it increases by one after each `xing_tick`. A frame carries the value the counter had in the write cycle, before that cycle's increment.
- R5: The memory holds 128 frames. `mem_full` is high from the cycle after the 128th write until the memory is cleared. Writes that arrive while the memory is full are ignored, and the earlier frames are kept.
- R6: Frames are sent oldest first, in the order they were written.
- R7: `sdo_en` is high only while the chip holds the token, and `sdo` is 0 while `sdo_en` is low. The first bit is on `sdo` one cycle after `token_in`. `sdo` changes only in the cycle after a `bit_tick` and advances by exactly one bit per tick.
- R8: `token_out` is a one-cycle pulse. It comes one cycle after the `bit_tick` of the last bit of the last frame, or one cycle after `token_in` when no frame is stored. In that same cycle `sdo_en` falls, the memory empties and `mem_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_start | input | 1 | Pulse that zeroes the crossing number |
| xing_tick | input | 1 | One-cycle enable per bunch crossing |
| acq_on | input | 1 | Acquisition window is open |
| disc_lo | input | 64 | Low-threshold discriminator outputs |
| disc_hi | input | 64 | High-threshold discriminator outputs |
| chip_id | input | 8 | Value placed in the frame header |
| token_in | input | 1 | Token arrives from the previous chip |
| bit_tick | input | 1 | Serial bit-rate enable |
| token_out | output | 1 | Token pulse to the next chip |
| sdo | output | 1 | Serial data toward the shared line |
| sdo_en | output | 1 | Drive enable for the shared line |
| mem_full | output | 1 | All frame locations are used |

## Verification
A write shows on `mem_full` at the negative edge that follows the write cycle. The first serial bit appears one cycle after `token_in`, and each later bit appears one cycle after its `bit_tick`. The token and the release of the line come one cycle after the final tick, or one cycle after `token_in` when the memory is empty. The bench drives inputs and samples outputs at negative edges. It reads each bit at the edge that follows the tick that produced it. It inserts random idle cycles between ticks and checks that `sdo` holds still across them. It checks `token_out` at the exact edge where the pulse is due, and checks that the pulse has dropped one edge later.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  typedef enum logic {SER_IDLE = 1'b0, SER_SEND = 1'b1} ser_state_t;
endpackage

// File: rtl/hfs_xing_counter.sv
module hfs_xing_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= '0;
    else if (tick)  cnt <= cnt + W'(1);
  end

  a_r4_zero_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == '0);
  a_r4_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start) |=> cnt == $past(cnt) + W'(1));
endmodule

// File: rtl/hfs_frame_ram.sv
module hfs_frame_ram #(
  parameter int W     = 160,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [W-1:0]  wr_data,
  input  logic          clear,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          wr_fire
);
  logic [W-1:0] store [DEPTH];

  assign full    = (count == CW'(DEPTH));
  assign wr_fire = wr_req && !full && !clear;
  assign rd_data = store[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_fire) store[count[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (wr_fire) count <= count + CW'(1);
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clear) |=> full && $stable(count));
  a_r3_write_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !full && !clear) |=> count == $past(count) + CW'(1));
endmodule

// File: rtl/hfs_token_shifter.sv
module hfs_token_shifter
  import hfs_pkg::*;
#(
  parameter int W     = 160,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int BW   = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          token_in,
  input  logic          bit_tick,
  input  logic [CW-1:0] count,
  input  logic [W-1:0]  rd_data,
  output logic [AW-1:0] rd_idx,
  output logic          sdo,
  output logic          sdo_en,
  output logic          token_out,
  output logic          clear,
  output logic          busy
);
  ser_state_t    state;
  logic [W-1:0]  shreg;
  logic [BW-1:0] bitcnt;
  logic [AW-1:0] fidx;

  // named internal events
  logic start_ev, last_bit, last_frame, advance_ev, release_ev;
  assign start_ev   = (state == SER_IDLE) && token_in;
  assign last_bit   = (bitcnt == BW'(W - 1));
  assign last_frame = (CW'(fidx) + CW'(1) == count);
  assign advance_ev = (state == SER_SEND) && bit_tick;
  assign release_ev = (advance_ev && last_bit && last_frame) ||
                      (start_ev && count == '0);

  assign clear  = release_ev;
  assign busy   = (state == SER_SEND);
  assign rd_idx = busy ? fidx + AW'(1) : '0;
  assign sdo_en = busy;
  assign sdo    = busy && shreg[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SER_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      fidx      <= '0;
      token_out <= 1'b0;
    end else begin
      token_out <= release_ev;
      if (start_ev && count != '0) begin
        state  <= SER_SEND;
        shreg  <= rd_data;
        bitcnt <= '0;
        fidx   <= '0;
      end else if (advance_ev) begin
        if (!last_bit) begin
          shreg  <= {shreg[W-2:0], 1'b0};
          bitcnt <= bitcnt + BW'(1);
        end else if (last_frame) begin
          state <= SER_IDLE;
        end else begin
          shreg  <= rd_data;
          bitcnt <= '0;
          fidx   <= fidx + AW'(1);
        end
      end
    end
  end

  a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && !bit_tick) |=> sdo_en && $stable(sdo));
  a_r7_drive_needs_frames: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> count != '0);
  a_r8_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_ev && last_bit && last_frame) |=> token_out && !sdo_en);
  a_r8_no_token_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> !token_out);
endmodule

// File: rtl/hit_frame_store.sv
module hit_frame_store #(
  parameter int NCH    = 64,
  parameter int BCID_W = 24,
  parameter int HDR_W  = 8,
  parameter int DEPTH  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_start,
  input  logic             xing_tick,
  input  logic             acq_on,
  input  logic [NCH-1:0]   disc_lo,
  input  logic [NCH-1:0]   disc_hi,
  input  logic [HDR_W-1:0] chip_id,
  input  logic             token_in,
  input  logic             bit_tick,
  output logic             token_out,
  output logic             sdo,
  output logic             sdo_en,
  output logic             mem_full
);
  localparam int FRAME_W = HDR_W + BCID_W + 2 * NCH;
  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = $clog2(DEPTH + 1);

  function automatic logic [2*NCH-1:0] pack_codes(input logic [NCH-1:0] lo,
                                                  input logic [NCH-1:0] hi);
    logic [2*NCH-1:0] r;
    for (int k = 0; k < NCH; k++) r[2*k +: 2] = {hi[k], lo[k]};
    return r;
  endfunction

  logic [BCID_W-1:0]  bcid;
  logic [FRAME_W-1:0] wr_frame, rd_frame;
  logic [AW-1:0]      rd_idx;
  logic [CW-1:0]      count;
  logic               hit_any, wr_req, wr_fire, clear, busy;

  assign hit_any  = |(disc_lo | disc_hi);
  assign wr_req   = acq_on && xing_tick && hit_any && !busy;
  assign wr_frame = {chip_id, bcid, pack_codes(disc_lo, disc_hi)};

  hfs_xing_counter #(.W(BCID_W)) u_xing (
    .clk(clk), .rst_n(rst_n), .start(train_start), .tick(xing_tick), .cnt(bcid)
  );

  hfs_frame_ram #(.W(FRAME_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_frame),
    .clear(clear), .rd_idx(rd_idx), .rd_data(rd_frame), .count(count),
    .full(mem_full), .wr_fire(wr_fire)
  );

  hfs_token_shifter #(.W(FRAME_W), .DEPTH(DEPTH)) u_ser (
    .clk(clk), .rst_n(rst_n), .token_in(token_in), .bit_tick(bit_tick),
    .count(count), .rd_data(rd_frame), .rd_idx(rd_idx), .sdo(sdo),
    .sdo_en(sdo_en), .token_out(token_out), .clear(clear), .busy(busy)
  );

  a_r3_no_write_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_any || !acq_on || !xing_tick) |-> !wr_fire);
  a_r3_no_write_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> !wr_fire);
endmodule

// File: tb/tb_hit_frame_store.sv
`timescale 1ns/1ps
module tb_hit_frame_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        train_start = 1'b0, xing_tick = 1'b0, acq_on = 1'b0;
  logic [63:0] disc_lo = '0, disc_hi = '0;
  logic [7:0]  chip_id = '0;
  logic        token_in = 1'b0, bit_tick = 1'b0;
  logic        token_out, sdo, sdo_en, mem_full;

  int checks = 0, errors = 0;
  logic [159:0] expq[$];
  logic [23:0]  mbcid = '0;

  always #2.5 clk = ~clk;

  hit_frame_store dut (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .xing_tick(xing_tick),
    .acq_on(acq_on), .disc_lo(disc_lo), .disc_hi(disc_hi), .chip_id(chip_id),
    .token_in(token_in), .bit_tick(bit_tick), .token_out(token_out), .sdo(sdo),
    .sdo_en(sdo_en), .mem_full(mem_full)
  );

  function automatic logic [159:0] model_frame(input logic [7:0] id, input logic [23:0] bc,
                                               input logic [63:0] lo, input logic [63:0] hi);
    logic [159:0] f;
    f = {128'd0, id, bc};
    for (int k = 63; k >= 0; k--) f = (f << 2) | {158'd0, hi[k], lo[k]};
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; the model mirrors the requirements R3, R4, R5
  task automatic cycle(input bit start, input bit tick, input logic [63:0] lo,
                       input logic [63:0] hi);
    train_start = start; xing_tick = tick; disc_lo = lo; disc_hi = hi;
    if (tick && acq_on && ((lo | hi) != 0) && expq.size() < 128)
      expq.push_back(model_frame(chip_id, mbcid, lo, hi));
    if (start) mbcid = '0;
    else if (tick) mbcid = mbcid + 24'd1;
    @(negedge clk);
    train_start = 1'b0; xing_tick = 1'b0; disc_lo = '0; disc_hi = '0;
  endtask

  task automatic readout(input string tag);
    int n;
    n = expq.size();
    token_in = 1'b1; @(negedge clk); token_in = 1'b0;
    for (int f = 0; f < n; f++) begin
      logic [159:0] got;
      bit en_ok, hold_ok;
      got = '0; en_ok = 1; hold_ok = 1;
      for (int b = 0; b < 160; b++) begin
        int gap;
        if (!sdo_en) en_ok = 0;
        got = {got[158:0], sdo};
        gap = $urandom % 3;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (sdo !== got[0] || !sdo_en) hold_ok = 0;
        end
        bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0;
      end
      chk(got === expq[f], "R1 R2 R6", {tag, " frame content"}, got, expq[f]);
      chk(en_ok, "R7", {tag, " sdo_en during frame"}, 160'(en_ok), 160'd1);
      chk(hold_ok, "R7", {tag, " sdo stable between ticks"}, 160'(hold_ok), 160'd1);
    end
    chk(token_out === 1'b1 && sdo_en === 1'b0 && mem_full === 1'b0, "R8",
        {tag, " token_out after last bit"}, {157'd0, token_out, sdo_en, mem_full}, 160'b100);
    @(negedge clk);
    chk(token_out === 1'b0 && sdo === 1'b0, "R8", {tag, " token pulse one cycle"},
        {158'd0, token_out, sdo}, 160'd0);
    expq.delete();
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sdo_en && !token_out && !mem_full && !sdo, "R7 R8", "reset state",
        {156'd0, sdo_en, token_out, mem_full, sdo}, 160'd0);

    // R8: empty memory passes the token at once
    token_in = 1'b1; @(negedge clk); token_in = 1'b0;
    chk(token_out === 1'b1 && !sdo_en, "R8", "empty token pass",
        {158'd0, token_out, sdo_en}, 160'b10);
    @(negedge clk);
    chk(token_out === 1'b0, "R8", "empty token pulse width", 160'(token_out), 160'd0);

    // random train (R1-R4, R6)
    chip_id = 8'h5A; acq_on = 1'b1;
    cycle(1, 0, '0, '0);
    for (int i = 0; i < 60; i++) begin
      logic [63:0] lo, hi;
      int mode;
      mode = $urandom % 5;
      lo = '0; hi = '0;
      case (mode)
        1: lo[$urandom % 64] = 1'b1;
        2: lo = {$urandom, $urandom};
        3: begin lo = {$urandom, $urandom}; hi = {$urandom, $urandom} & lo; end
        4: hi[$urandom % 64] = 1'b1;
        default: ;
      endcase
      cycle(0, ($urandom % 4) != 0, lo, hi);
    end
    acq_on = 1'b0;
    @(negedge clk);
    chk(mem_full === 1'b0, "R5", "not full after partial train", 160'(mem_full), 160'd0);
    readout("random train");

    // directed: start and tick together, then field positions (R4, R1)
    chip_id = 8'hC3; acq_on = 1'b1;
    cycle(0, 1, '0, '0);
    cycle(1, 1, '0, '0);
    cycle(0, 1, 64'h1, 64'h0);
    cycle(0, 1, 64'h0, 64'h8000_0000_0000_0000);
    cycle(0, 0, '1, '1);
    cycle(0, 1, '1, '1);
    acq_on = 1'b0;
    @(negedge clk);
    chk(expq.size() == 3 && expq[0][151:128] == 24'd0, "R4", "start wins over tick",
        160'(expq[0][151:128]), 160'd0);
    readout("directed fields");

    // fill the memory (R5)
    chip_id = 8'h17; acq_on = 1'b1;
    cycle(1, 0, '0, '0);
    for (int i = 0; i < 128; i++) cycle(0, 1, {$urandom, $urandom} | 64'h1, {$urandom, $urandom});
    chk(mem_full === 1'b1, "R5", "full after 128 writes", 160'(mem_full), 160'd1);
    cycle(0, 1, 64'hFFFF, 64'hFFFF);
    cycle(0, 1, 64'h00F0, 64'h0);
    chk(mem_full === 1'b1, "R5", "full holds after extra triggers", 160'(mem_full), 160'd1);
    acq_on = 1'b0;
    @(negedge clk);
    readout("full memory");
    chk(mem_full === 1'b0, "R5 R8", "full cleared after readout", 160'(mem_full), 160'd0);

    // R3: hits with acquisition closed store nothing
    cycle(0, 1, '1, '1);
    cycle(0, 1, 64'h5, 64'h0);
    token_in = 1'b1; @(negedge clk); token_in = 1'b0;
    chk(token_out === 1'b1 && !sdo_en, "R3", "no frame with acq_on low",
        {158'd0, token_out, sdo_en}, 160'b10);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule